// File: doc/BRIEF.md
# Sensor Polling Interval Scheduler

This block paces periodic temperature sampling for one thermal controller that serves up to four sensing points. A shared time base divides a fast reference clock into a period unit. Three separately programmed gaps, each a whole number of period units, are placed between consecutive samples of one point, between one point and the next, and after the last point of a sweep. Each sample is a request and done handshake with the measurement engine. For each finished sample the block gives a one-cycle strobe on that point's lane.

The configuration (period multiplier, filter mode, active point count and the three gaps) is captured when the scheduler leaves idle, so software may rewrite it during a sweep without disturbing that sweep. The filter mode sets how many samples each point receives before the scheduler moves on. A 3-bit status code shows whether the scheduler is idle, sampling, or inside one of the three gaps. Clearing the enable input parks the scheduler at the next sample boundary.

Top module: `sensor_poll_sched`

## Requirements
- R1: After reset, and while enable has never been raised, status is 000, meas_req is low, sample_strobe is all zero and sweep_done is low.
- R2: One period unit lasts max(period_count,1) x PRESCALE_BASE clock cycles. A gap of G units keeps meas_req low for exactly G x unit + 1 cycles, and a gap of 0 units keeps it low for 1 cycle.
- R3: filter_mode sets the samples taken per point: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 6, 4 gives 10, 5 gives 18, and 6 or 7 give 1.
- R4: Points are served in ascending order from 0 to S-1, each with all of its samples back to back. S is num_points clamped to 1..4, and a value of 0 counts as 1.
- R5: filt_gap separates samples of the same point, sens_gap separates the last sample of one point from the first sample of the next, and group_gap follows the last sample of the last point.
- R6: meas_req stays high with meas_point unchanged until meas_done is seen. One cycle after that cycle, sample_strobe has exactly bit meas_point set, for one cycle.
- R7: sweep_done pulses for one cycle in the first cycle after the group gap expires, and in that cycle meas_req is high with meas_point equal to 0.
- R8: status encodes 000 idle, 001 sampling, 100 filter gap, 111 sensor gap, 011 group gap, and no other value appears.
- R9: With enable low, a gap ends and status returns to 000 on the next clock. A pending sample keeps its request until meas_done, gives its strobe, and then returns to idle. No further request follows while enable stays low.
- R10: At most one bit of sample_strobe is set in any cycle.
- R11: Configuration inputs changed while a run is active have no effect on that run's order, sample counts or gap lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run request; low parks the scheduler at the next sample boundary |
| period_count | input | PC_W (8) | Period unit multiplier, 0 treated as 1 |
| filter_mode | input | 3 | Samples per point selector |
| num_points | input | 3 | Active sensing points, clamped to 1..4 |
| filt_gap | input | GAP_W (8) | Units between samples of one point |
| sens_gap | input | GAP_W (8) | Units between points |
| group_gap | input | GAP_W (8) | Units after the last point of a sweep |
| meas_done | input | 1 | Measurement engine finished the requested sample |
| meas_req | output | 1 | Sample request, held until meas_done |
| meas_point | output | 2 | Point addressed by the current request |
| sample_strobe | output | 4 | One-cycle pulse on the lane of the point just sampled |
| sweep_done | output | 1 | One-cycle pulse when a sweep restarts at point 0 |
| status | output | 3 | Scheduler state code |

## Verification
The bench measures every idle stretch of meas_req in cycles and compares it with G x unit + 1. A prescaler that runs freely instead of restarting at each gap, or that treats a multiplier of zero as 256, would show gaps that drift or differ by a whole unit. Sweeps with one point, with four points and with 18 samples per point expose an off-by-one in the last-sample or last-point test, which would add or drop a strobe or use the wrong gap kind. Rewriting the configuration in the middle of a run, and dropping enable both inside a gap and during a pending request, expose designs that read their settings live or that leave a request hanging.

// File: rtl/sps_pkg.sv
package sps_pkg;

    // State encoding doubles as the externally visible status code.
    typedef enum logic [2:0] {
        SPS_IDLE   = 3'b000,
        SPS_SAMPLE = 3'b001,
        SPS_FGAP   = 3'b100,
        SPS_SGAP   = 3'b111,
        SPS_GGAP   = 3'b011
    } sps_state_e;

    // Gap kinds, used as indices into the gap counter array.
    localparam int GAP_KINDS = 3;
    localparam int GK_FILT   = 0;
    localparam int GK_SENS   = 1;
    localparam int GK_GRP    = 2;

    // Width of the per-point sample count (largest mode takes 18).
    localparam int SMP_W = 5;

    function automatic logic [SMP_W-1:0] samples_for_mode(input logic [2:0] mode);
        logic [SMP_W-1:0] n;
        case (mode)
            3'd1:    n = SMP_W'(2);
            3'd2:    n = SMP_W'(4);
            3'd3:    n = SMP_W'(6);
            3'd4:    n = SMP_W'(10);
            3'd5:    n = SMP_W'(18);
            default: n = SMP_W'(1);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sps_unit_prescaler.sv
module sps_unit_prescaler #(
    parameter int PRESCALE_BASE = 256,
    parameter int PC_W          = 8,
    localparam int SUB_W        = (PRESCALE_BASE > 1) ? $clog2(PRESCALE_BASE) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            run,
    input  logic [PC_W-1:0] unit_count,
    output logic            unit_tick
);

    logic [SUB_W-1:0] sub_q;
    logic [PC_W-1:0]  mult_q;
    logic [PC_W-1:0]  mult_last;
    logic             sub_wrap;

    // A multiplier of zero behaves as one.
    assign mult_last = (unit_count == '0) ? '0 : unit_count - 1'b1;
    assign sub_wrap  = (sub_q == SUB_W'(PRESCALE_BASE - 1));
    assign unit_tick = run && sub_wrap && (mult_q == mult_last);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sub_q  <= '0;
            mult_q <= '0;
        end else if (run) begin
            if (sub_wrap) begin
                sub_q  <= '0;
                mult_q <= (mult_q == mult_last) ? '0 : mult_q + 1'b1;
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sps_gap_counter.sv
module sps_gap_counter #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [GAP_W-1:0] load_value,
    input  logic             tick,
    output logic             expired
);

    logic [GAP_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_value;
        end else if (tick && (remain_q != '0)) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign expired = (remain_q == '0);

endmodule

// File: rtl/sps_sequencer.sv
module sps_sequencer
    import sps_pkg::*;
#(
    parameter int MAX_POINTS = 4,
    parameter int GAP_W      = 8,
    parameter int PC_W       = 8,
    localparam int PT_W      = $clog2(MAX_POINTS),
    localparam int NP_W      = $clog2(MAX_POINTS + 1)
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               enable,
    input  logic [PC_W-1:0]                    period_count,
    input  logic [2:0]                         filter_mode,
    input  logic [NP_W-1:0]                    num_points,
    input  logic [GAP_W-1:0]                   filt_gap,
    input  logic [GAP_W-1:0]                   sens_gap,
    input  logic [GAP_W-1:0]                   group_gap,
    input  logic                               meas_done,
    input  logic [GAP_KINDS-1:0]               gap_expired,
    output logic [GAP_KINDS-1:0]               gap_load,
    output logic [GAP_KINDS-1:0][GAP_W-1:0]    gap_value,
    output logic [GAP_KINDS-1:0]               gap_active,
    output logic [PC_W-1:0]                    unit_count,
    output logic                               pre_clear,
    output logic                               pre_run,
    output sps_state_e                         state,
    output logic [PT_W-1:0]                    point,
    output logic [MAX_POINTS-1:0]              strobe,
    output logic                               sweep_pulse
);

    typedef struct packed {
        logic [SMP_W-1:0]                  nsamp;
        logic [PT_W-1:0]                   last_pt;
        logic [PC_W-1:0]                   ucount;
        logic [GAP_KINDS-1:0][GAP_W-1:0]   gaps;
    } run_cfg_t;

    run_cfg_t         cfg_q;
    run_cfg_t         cfg_in;
    sps_state_e       state_q;
    logic [PT_W-1:0]  point_q;
    logic [SMP_W-1:0] smp_q;
    logic [PT_W-1:0]  last_pt_in;
    logic             sample_end;
    logic             last_sample;
    logic             last_point;

    // Clamp the requested point count to 1..MAX_POINTS.
    always_comb begin
        if (num_points == '0) begin
            last_pt_in = '0;
        end else if (num_points >= NP_W'(MAX_POINTS)) begin
            last_pt_in = PT_W'(MAX_POINTS - 1);
        end else begin
            last_pt_in = PT_W'(num_points - 1'b1);
        end
    end

    always_comb begin
        cfg_in.nsamp         = samples_for_mode(filter_mode);
        cfg_in.last_pt       = last_pt_in;
        cfg_in.ucount        = period_count;
        cfg_in.gaps[GK_FILT] = filt_gap;
        cfg_in.gaps[GK_SENS] = sens_gap;
        cfg_in.gaps[GK_GRP]  = group_gap;
    end

    assign sample_end  = (state_q == SPS_SAMPLE) && meas_done;
    assign last_sample = (smp_q == cfg_q.nsamp - 1'b1);
    assign last_point  = (point_q == cfg_q.last_pt);

    always_comb begin
        gap_load          = '0;
        gap_load[GK_FILT] = sample_end && enable && !last_sample;
        gap_load[GK_SENS] = sample_end && enable && last_sample && !last_point;
        gap_load[GK_GRP]  = sample_end && enable && last_sample && last_point;
        gap_active          = '0;
        gap_active[GK_FILT] = (state_q == SPS_FGAP);
        gap_active[GK_SENS] = (state_q == SPS_SGAP);
        gap_active[GK_GRP]  = (state_q == SPS_GGAP);
    end

    assign gap_value  = cfg_q.gaps;
    assign unit_count = cfg_q.ucount;
    assign pre_clear  = |gap_load;
    assign pre_run    = |gap_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= SPS_IDLE;
            point_q     <= '0;
            smp_q       <= '0;
            cfg_q       <= '0;
            strobe      <= '0;
            sweep_pulse <= 1'b0;
        end else begin
            strobe      <= '0;
            sweep_pulse <= 1'b0;
            case (state_q)
                SPS_IDLE: begin
                    if (enable) begin
                        cfg_q   <= cfg_in;
                        point_q <= '0;
                        smp_q   <= '0;
                        state_q <= SPS_SAMPLE;
                    end
                end
                SPS_SAMPLE: begin
                    if (meas_done) begin
                        strobe <= MAX_POINTS'(1) << point_q;
                        if (!enable) begin
                            state_q <= SPS_IDLE;
                        end else if (gap_load[GK_FILT]) begin
                            smp_q   <= smp_q + 1'b1;
                            state_q <= SPS_FGAP;
                        end else if (gap_load[GK_SENS]) begin
                            smp_q   <= '0;
                            point_q <= point_q + 1'b1;
                            state_q <= SPS_SGAP;
                        end else begin
                            state_q <= SPS_GGAP;
                        end
                    end
                end
                SPS_FGAP: begin
                    if (!enable) begin
                        state_q <= SPS_IDLE;
                    end else if (gap_expired[GK_FILT]) begin
                        state_q <= SPS_SAMPLE;
                    end
                end
                SPS_SGAP: begin
                    if (!enable) begin
                        state_q <= SPS_IDLE;
                    end else if (gap_expired[GK_SENS]) begin
                        state_q <= SPS_SAMPLE;
                    end
                end
                SPS_GGAP: begin
                    if (!enable) begin
                        state_q <= SPS_IDLE;
                    end else if (gap_expired[GK_GRP]) begin
                        point_q     <= '0;
                        smp_q       <= '0;
                        sweep_pulse <= 1'b1;
                        state_q     <= SPS_SAMPLE;
                    end
                end
                default: state_q <= SPS_IDLE;
            endcase
        end
    end

    assign state = state_q;
    assign point = point_q;

endmodule

// File: rtl/sensor_poll_sched.sv
module sensor_poll_sched
    import sps_pkg::*;
#(
    parameter int MAX_POINTS    = 4,
    parameter int PRESCALE_BASE = 256,
    parameter int PC_W          = 8,
    parameter int GAP_W         = 8,
    localparam int PT_W         = $clog2(MAX_POINTS),
    localparam int NP_W         = $clog2(MAX_POINTS + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enable,
    input  logic [PC_W-1:0]       period_count,
    input  logic [2:0]            filter_mode,
    input  logic [NP_W-1:0]       num_points,
    input  logic [GAP_W-1:0]      filt_gap,
    input  logic [GAP_W-1:0]      sens_gap,
    input  logic [GAP_W-1:0]      group_gap,
    input  logic                  meas_done,
    output logic                  meas_req,
    output logic [PT_W-1:0]       meas_point,
    output logic [MAX_POINTS-1:0] sample_strobe,
    output logic                  sweep_done,
    output logic [2:0]            status
);

    logic [GAP_KINDS-1:0]            gap_load;
    logic [GAP_KINDS-1:0][GAP_W-1:0] gap_value;
    logic [GAP_KINDS-1:0]            gap_active;
    logic [GAP_KINDS-1:0]            gap_expired;
    logic [PC_W-1:0]                 unit_count;
    logic                            pre_clear;
    logic                            pre_run;
    logic                            unit_tick;
    sps_state_e                      state_w;
    logic [PT_W-1:0]                 point_w;

    sps_sequencer #(
        .MAX_POINTS (MAX_POINTS),
        .GAP_W      (GAP_W),
        .PC_W       (PC_W)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .period_count (period_count),
        .filter_mode  (filter_mode),
        .num_points   (num_points),
        .filt_gap     (filt_gap),
        .sens_gap     (sens_gap),
        .group_gap    (group_gap),
        .meas_done    (meas_done),
        .gap_expired  (gap_expired),
        .gap_load     (gap_load),
        .gap_value    (gap_value),
        .gap_active   (gap_active),
        .unit_count   (unit_count),
        .pre_clear    (pre_clear),
        .pre_run      (pre_run),
        .state        (state_w),
        .point        (point_w),
        .strobe       (sample_strobe),
        .sweep_pulse  (sweep_done)
    );

    sps_unit_prescaler #(
        .PRESCALE_BASE (PRESCALE_BASE),
        .PC_W          (PC_W)
    ) u_pre (
        .clk        (clk),
        .rst        (rst),
        .clear      (pre_clear),
        .run        (pre_run),
        .unit_count (unit_count),
        .unit_tick  (unit_tick)
    );

    for (genvar k = 0; k < GAP_KINDS; k++) begin : g_gap
        sps_gap_counter #(
            .GAP_W (GAP_W)
        ) u_gap (
            .clk        (clk),
            .rst        (rst),
            .load       (gap_load[k]),
            .load_value (gap_value[k]),
            .tick       (unit_tick && gap_active[k]),
            .expired    (gap_expired[k])
        );
    end

    assign meas_req   = (state_w == SPS_SAMPLE);
    assign meas_point = point_w;
    assign status     = state_w;

endmodule

// File: rtl/sps_checker.sv
module sps_checker #(
    parameter int MAX_POINTS = 4,
    localparam int PT_W      = $clog2(MAX_POINTS)
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  enable,
    input logic                  meas_req,
    input logic                  meas_done,
    input logic [PT_W-1:0]       meas_point,
    input logic [MAX_POINTS-1:0] sample_strobe,
    input logic                  sweep_done,
    input logic [2:0]            status
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        meas_req && !meas_done |=> meas_req && $stable(meas_point)); // R6

    AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        |sample_strobe |-> $past(meas_req && meas_done)); // R6

    AST_STROBE_LANE: assert property (@(posedge clk) disable iff (rst)
        |sample_strobe |-> sample_strobe == (MAX_POINTS'(1) << $past(meas_point))); // R6

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sample_strobe)); // R10

    AST_SWEEP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sweep_done |=> !sweep_done); // R7

    AST_SWEEP_RESTART: assert property (@(posedge clk) disable iff (rst)
        sweep_done |-> meas_req && meas_point == '0); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        status == 3'b000 |-> !meas_req && !sweep_done); // R1

    AST_LEGAL_STATUS: assert property (@(posedge clk) disable iff (rst)
        status inside {3'b000, 3'b001, 3'b100, 3'b111, 3'b011}); // R8

    AST_GAP_ABORT: assert property (@(posedge clk) disable iff (rst)
        !enable && (status inside {3'b100, 3'b111, 3'b011}) |=> status == 3'b000); // R9

    AST_DONE_PARKS: assert property (@(posedge clk) disable iff (rst)
        meas_req && meas_done && !enable |=> status == 3'b000); // R9

endmodule

bind sensor_poll_sched sps_checker #(
    .MAX_POINTS (MAX_POINTS)
) u_sps_chk (
    .clk           (clk),
    .rst           (rst),
    .enable        (enable),
    .meas_req      (meas_req),
    .meas_done     (meas_done),
    .meas_point    (meas_point),
    .sample_strobe (sample_strobe),
    .sweep_done    (sweep_done),
    .status        (status)
);

// File: tb/tb_sensor_poll_sched.sv
module tb_sensor_poll_sched;

    localparam int BASE       = 256;
    localparam int RESP_DELAY = 3;

    typedef struct {
        int kind;   // 0 strobe, 1 gap, 2 sweep
        int val;
        int st;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst;
    logic       enable;
    logic [7:0] period_count;
    logic [2:0] filter_mode;
    logic [2:0] num_points;
    logic [7:0] filt_gap;
    logic [7:0] sens_gap;
    logic [7:0] group_gap;
    logic       meas_done;
    logic       meas_req;
    logic [1:0] meas_point;
    logic [3:0] sample_strobe;
    logic       sweep_done;
    logic [2:0] status;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_err = 0;
    int   total_strobes = 0;
    bit   mon_on = 0;
    bit   armed = 0;
    int   low_run = 0;
    int   gap_st = 0;
    bit   prev_req = 0;

    always #4 clk = ~clk;

    sensor_poll_sched dut (
        .clk           (clk),
        .rst           (rst),
        .enable        (enable),
        .period_count  (period_count),
        .filter_mode   (filter_mode),
        .num_points    (num_points),
        .filt_gap      (filt_gap),
        .sens_gap      (sens_gap),
        .group_gap     (group_gap),
        .meas_done     (meas_done),
        .meas_req      (meas_req),
        .meas_point    (meas_point),
        .sample_strobe (sample_strobe),
        .sweep_done    (sweep_done),
        .status        (status)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    function automatic int samples_of(input int mode);
        case (mode)
            1: return 2;
            2: return 4;
            3: return 6;
            4: return 10;
            5: return 18;
            default: return 1;
        endcase
    endfunction

    // Measurement engine model: answers each request after RESP_DELAY cycles.
    initial begin
        int wait_cnt = 0;
        meas_done = 1'b0;
        forever begin
            @(negedge clk);
            if (meas_done) begin
                meas_done = 1'b0;
            end else if (meas_req) begin
                if (wait_cnt == RESP_DELAY - 1) begin
                    meas_done = 1'b1;
                    wait_cnt = 0;
                end else begin
                    wait_cnt++;
                end
            end else begin
                wait_cnt = 0;
            end
        end
    end

    task automatic pop_expect(input int kind, output bit got, output exp_t e);
        got = 0;
        e = '{kind: -1, val: 0, st: 0};
        if (exp_q.size() == 0) begin
            chk(0, "R4 R5 unexpected event", kind, -1);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != kind) chk(0, "R5 event order", kind, e.kind);
            else got = 1;
        end
    endtask

    // Monitor: pops expected items as the design produces them.
    initial begin
        forever begin
            @(negedge clk);
            if (|sample_strobe) begin
                total_strobes++;
                if (mon_on) begin
                    bit   got;
                    exp_t e;
                    armed = 1;
                    pop_expect(0, got, e);
                    if (got) chk(sample_strobe == 4'(e.val), "R4 R6 R10 strobe lane",
                                 int'(sample_strobe), e.val);
                end
            end
            if (!meas_req) begin
                if (prev_req) begin
                    low_run = 1;
                    gap_st = int'(status);
                end else begin
                    low_run++;
                end
            end else if (!prev_req && mon_on) begin
                chk(status == 3'b001, "R8 sampling status", int'(status), 1);
                if (armed) begin
                    bit   got;
                    exp_t e;
                    pop_expect(1, got, e);
                    if (got) begin
                        chk(low_run == e.val, "R2 R5 gap length", low_run, e.val);
                        chk(gap_st == e.st, "R8 gap status", gap_st, e.st);
                    end
                end
            end
            if (sweep_done && mon_on) begin
                bit   got;
                exp_t e;
                pop_expect(2, got, e);
                if (got) chk(meas_point == 2'd0, "R7 restart point", int'(meas_point), 0);
            end
            prev_req = meas_req;
        end
    end

    task automatic run_cfg(input int pc, input int np, input int mode, input int fg,
                           input int sg, input int gg, input int sweeps, input bit scramble);
        int s_eff = (np == 0) ? 1 : ((np > 4) ? 4 : np);
        int n_eff = samples_of(mode);
        int unit  = ((pc == 0) ? 1 : pc) * BASE;
        for (int s = 0; s < sweeps; s++) begin
            for (int p = 0; p < s_eff; p++) begin
                for (int n = 0; n < n_eff; n++) begin
                    exp_q.push_back('{kind: 0, val: (1 << p), st: 0});
                    if (n < n_eff - 1)
                        exp_q.push_back('{kind: 1, val: fg * unit + 1, st: 3'b100});
                    else if (p < s_eff - 1)
                        exp_q.push_back('{kind: 1, val: sg * unit + 1, st: 3'b111});
                    else begin
                        exp_q.push_back('{kind: 1, val: gg * unit + 1, st: 3'b011});
                        exp_q.push_back('{kind: 2, val: 0, st: 0});
                    end
                end
            end
        end
        exp_q.push_back('{kind: 0, val: 1, st: 0});  // trailing sample finished on disable (R9)
        @(posedge clk); #2;
        period_count = 8'(pc); num_points = 3'(np); filter_mode = 3'(mode);
        filt_gap = 8'(fg); sens_gap = 8'(sg); group_gap = 8'(gg);
        armed = 0; mon_on = 1; enable = 1'b1;
        if (scramble) begin
            repeat (3) @(posedge clk);
            #2;
            // R11: mid-run rewrite must not alter the run
            period_count = 8'd7; num_points = 3'd1; filter_mode = 3'd0;
            filt_gap = 8'd0; sens_gap = 8'd0; group_gap = 8'd0;
        end
        for (int c = 0; c < 60000 && exp_q.size() > 1; c++) begin
            @(posedge clk); #2;
        end
        enable = 1'b0;
        for (int c = 0; c < 200 && !(exp_q.size() == 0 && status == 3'b000); c++) begin
            @(posedge clk); #2;
        end
        mon_on = 0;
        chk(exp_q.size() == 0, "R4 R11 all expected events seen", exp_q.size(), 0);
        chk(status == 3'b000 && !meas_req, "R9 idle after disable", int'(status), 0);
        exp_q.delete();
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
        report();
        $finish;
    end

    initial begin
        int s0;
        rst = 1'b1; enable = 1'b0;
        period_count = 8'd1; filter_mode = 3'd0; num_points = 3'd1;
        filt_gap = 8'd0; sens_gap = 8'd0; group_gap = 8'd0;
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        chk(status == 3'b000, "R1 reset status", int'(status), 0);
        chk(!meas_req && !sweep_done, "R1 reset request", int'(meas_req), 0);
        chk(sample_strobe == 4'd0, "R1 reset strobe", int'(sample_strobe), 0);
        repeat (50) @(posedge clk);
        #2 chk(!meas_req && status == 3'b000, "R1 stays idle without enable", int'(status), 0);

        // pc, points, mode, filt, sens, group, sweeps, scramble
        run_cfg(2, 2, 1, 1, 2, 3, 2, 1);  // R3 mode 1, R5 all gap kinds, R11
        run_cfg(1, 4, 0, 5, 0, 1, 1, 0);  // R4 four points, zero sensor gap
        run_cfg(3, 1, 2, 2, 0, 0, 1, 0);  // R3 mode 2, single point, zero group gap
        run_cfg(0, 3, 5, 0, 1, 0, 1, 0);  // R2 multiplier 0, R3 mode 5
        run_cfg(1, 0, 7, 3, 3, 1, 2, 0);  // R4 zero points as one, R3 mode 7

        // R9: enable dropped inside a filter gap
        @(posedge clk); #2;
        period_count = 8'd1; num_points = 3'd1; filter_mode = 3'd1;
        filt_gap = 8'd5; sens_gap = 8'd0; group_gap = 8'd2;
        s0 = total_strobes;
        enable = 1'b1;
        for (int c = 0; c < 100 && total_strobes == s0; c++) begin
            @(posedge clk); #2;
        end
        repeat (10) @(posedge clk);
        #2 chk(status == 3'b100, "R8 filter gap status", int'(status), 4);
        enable = 1'b0;
        @(posedge clk);
        #2 chk(status == 3'b000 && !meas_req, "R9 gap abort to idle", int'(status), 0);
        s0 = total_strobes;
        repeat (1500) @(posedge clk);
        #2 chk(total_strobes == s0 && !meas_req, "R9 no sampling while disabled",
               total_strobes - s0, 0);

        // R9: enable dropped while a request is pending
        enable = 1'b1;
        for (int c = 0; c < 20 && !meas_req; c++) begin
            @(posedge clk); #2;
        end
        enable = 1'b0;
        s0 = total_strobes;
        chk(meas_req == 1'b1, "R6 request held pending done", int'(meas_req), 1);
        repeat (20) @(posedge clk);
        #2 chk(total_strobes == s0 + 1, "R9 pending sample completes", total_strobes - s0, 1);
        chk(status == 3'b000 && !meas_req, "R9 idle after pending sample", int'(status), 0);

        report();
        $finish;
    end

endmodule